// File: doc/BRIEF.md
# Conversion Result Bank with Coherent Byte Reads

This block keeps the latest 10-bit result for each of sixteen analog input channels and lets a host read them. The converter side presents a channel index, a result and a write strobe; the result lands in that channel's slot at the next clock edge. Each slot reads as a 16-bit value with the result packed into the top ten bits and six zero bits below.

The host reads over an 8-bit bus. Fetching the upper byte of a slot copies that slot's lower byte into one shadow byte, shared by all channels. A later lower-byte fetch returns the shadow instead of the live slot. An upper-then-lower pair therefore gives two halves of the same result, even if the converter writes a new result between the two fetches. A separate word-wide port returns a whole slot in one access and also loads the shadow byte.

The byte port is driven by a two-state machine. `BP_IDLE` is the state after reset: no capture has happened yet, and a lower-byte fetch returns zero. `BP_ARMED` means the shadow holds a captured byte. The transition `IDLE->ARMED` fires on the first capture, which is an upper-byte fetch or a word read. `ARMED->ARMED` repeats on every later capture. Only reset leaves `BP_ARMED`.

Top module: `adc_result_bank`

## Requirements
- R1: A converter write with channel index N and result V updates slot N only; every other slot keeps its value.
- R2: A slot reads as {V[9:0], 6'b000000}, so bits 5:0 of every slot are zero.
- R3: A byte fetch at an even address 2N returns bits 15:8 of slot N, which is V[9:2]. The data appears on `host_rdata` one clock after the strobe.
- R4: A byte fetch at an odd address 2N+1 returns the shadow byte, not the live slot. The shadow is loaded with bits 7:0 of slot N, which is {V[1:0], 6'b0}, by each even-address fetch of slot N.
- R5: A converter write to a channel between its upper and lower byte fetches does not change the lower byte returned; it comes from the value held at the upper fetch.
- R6: The shadow byte is shared by all channels, so an upper fetch of channel A followed by a lower fetch of channel B returns A's lower byte.
- R7: A word read of channel N returns the whole 16-bit slot on `word_rdata` one clock later. It also loads the shadow with that slot's bits 7:0.
- R8: Reset clears every slot, the shadow byte and both read outputs to zero. A lower-byte fetch before any capture returns 0x00.
- R9: Byte addresses are 5 bits: bits 4:1 select the channel and bit 0 selects the half (0 = upper, 1 = lower).
- R10: When an upper-byte fetch and a word read happen in the same cycle, the shadow takes the byte-fetched channel's lower byte.
- R11: A read in the same cycle as a converter write to the same channel returns the value from before that write.
- R12: Between read strobes, `host_rdata` and `word_rdata` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cv_wr | input | 1 | Converter result write strobe |
| cv_ch | input | 4 | Channel written by the converter |
| cv_res | input | 10 | Conversion result |
| host_rd | input | 1 | Byte fetch strobe |
| host_addr | input | 5 | Byte address: channel in bits 4:1, half select in bit 0 |
| host_rdata | output | 8 | Byte fetch data, valid one clock after the strobe |
| word_rd | input | 1 | Word read strobe |
| word_ch | input | 4 | Channel for the word read |
| word_rdata | output | 16 | Word read data, valid one clock after the strobe |

## Verification
A wrong shadow byte or byte-port state is hidden until the next odd-address fetch. It then shows on `host_rdata` one clock after that strobe, as a lower byte that matches neither the captured slot nor zero. A slot written to the wrong index shows on the very next upper-byte or word read of either the intended channel or the wrongly hit one. Random traffic that mixes captures from both read paths, cross-channel pairs and writes between fetches makes these differences show within a few accesses.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    typedef enum logic [0:0] {
        BP_IDLE  = 1'b0,
        BP_ARMED = 1'b1
    } bp_state_e;

endpackage

// File: rtl/adc_rb_store.sv
module adc_rb_store #(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 10,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_res,
    input  logic [CH_W-1:0]  rd_a_ch,
    output logic [RES_W-1:0] rd_a_res,
    input  logic [CH_W-1:0]  rd_b_ch,
    output logic [RES_W-1:0] rd_b_res
);

    logic [RES_W-1:0] slot [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(g))) begin
                slot[g] <= wr_res;
            end
        end
    end

    assign rd_a_res = slot[rd_a_ch];
    assign rd_b_res = slot[rd_b_ch];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot[$past(wr_ch)] == $past(wr_res))) else $error("write lost"); // R1

endmodule

// File: rtl/adc_rb_byte_port.sv
module adc_rb_byte_port
    import adc_rb_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 8,
    parameter int REG_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_low,
    input  logic [RES_W-1:0] byte_res,
    input  logic             word_en,
    input  logic [RES_W-1:0] word_res,
    output logic [BUS_W-1:0] rdata
);

    localparam int PAD_W = REG_W - RES_W;

    bp_state_e        state, state_nx;
    logic [BUS_W-1:0] shadow;
    logic [REG_W-1:0] byte_full, word_full;
    logic             hi_fetch, lo_fetch, capture;
    logic [BUS_W-1:0] cap_byte;

    assign byte_full = {byte_res, {PAD_W{1'b0}}};
    assign word_full = {word_res, {PAD_W{1'b0}}};
    assign hi_fetch  = rd_en && !rd_low;
    assign lo_fetch  = rd_en && rd_low;
    assign capture   = hi_fetch || word_en;
    // byte-path capture has priority over the word path
    assign cap_byte  = hi_fetch ? byte_full[BUS_W-1:0] : word_full[BUS_W-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            BP_IDLE:  if (capture) state_nx = BP_ARMED;
            BP_ARMED: state_nx = BP_ARMED;
            default:  state_nx = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BP_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            shadow <= '0;
        end else begin
            if (capture) shadow <= cap_byte;
            if (hi_fetch) begin
                rdata <= byte_full[REG_W-1:BUS_W];
            end else if (lo_fetch) begin
                unique case (state)
                    BP_IDLE:  rdata <= '0;
                    BP_ARMED: rdata <= shadow;
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(shadow)) else $error("shadow moved"); // R5
    AST_LOW_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        lo_fetch |=> (rdata == $past(shadow))) else $error("low byte"); // R4
    AST_IDLE_SHADOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BP_IDLE) |-> (shadow == '0)) else $error("idle shadow"); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)) else $error("rdata moved"); // R12

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 10,
    parameter int BUS_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cv_wr,
    input  logic [$clog2(NUM_CH)-1:0]    cv_ch,
    input  logic [RES_W-1:0]             cv_res,
    input  logic                         host_rd,
    input  logic [$clog2(NUM_CH):0]      host_addr,
    output logic [BUS_W-1:0]             host_rdata,
    input  logic                         word_rd,
    input  logic [$clog2(NUM_CH)-1:0]    word_ch,
    output logic [2*BUS_W-1:0]           word_rdata
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int REG_W = 2 * BUS_W;
    localparam int PAD_W = REG_W - RES_W;

    logic [CH_W-1:0]  byte_ch;
    logic             byte_low;
    logic [RES_W-1:0] byte_res, word_res;

    assign byte_ch  = host_addr[CH_W:1];
    assign byte_low = host_addr[0];

    adc_rb_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cv_wr),
        .wr_ch   (cv_ch),
        .wr_res  (cv_res),
        .rd_a_ch (byte_ch),
        .rd_a_res(byte_res),
        .rd_b_ch (word_ch),
        .rd_b_res(word_res)
    );

    adc_rb_byte_port #(.RES_W(RES_W), .BUS_W(BUS_W), .REG_W(REG_W)) u_byte (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (host_rd),
        .rd_low  (byte_low),
        .byte_res(byte_res),
        .word_en (word_rd),
        .word_res(word_res),
        .rdata   (host_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_rdata <= '0;
        else if (word_rd) word_rdata <= {word_res, {PAD_W{1'b0}}};
    end

    AST_WORD_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd |=> (word_rdata[PAD_W-1:0] == '0)) else $error("pad bits"); // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_rd |=> $stable(word_rdata)) else $error("word moved"); // R12
    AST_HI_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !byte_low && word_rd && (byte_ch == word_ch))
        |=> (host_rdata == word_rdata[REG_W-1:BUS_W])) else $error("hi/word"); // R3

endmodule

// File: tb/test_adc_result_bank.sv
`timescale 1ns/1ps
module test_adc_result_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv_wr = 1'b0;
    logic [3:0]  cv_ch = '0;
    logic [9:0]  cv_res = '0;
    logic        host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_rdata;
    logic        word_rd = 1'b0;
    logic [3:0]  word_ch = '0;
    logic [15:0] word_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [9:0] m_slot [16];
    logic [7:0] m_shadow;
    logic [7:0] m_byte;
    logic [15:0] m_word;

    always #5 clk = ~clk;

    adc_result_bank i_adc_result_bank (
        .clk(clk), .rst_n(rst_n), .cv_wr(cv_wr), .cv_ch(cv_ch), .cv_res(cv_res),
        .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
        .word_rd(word_rd), .word_ch(word_ch), .word_rdata(word_rdata)
    );

    function automatic logic [7:0] f_hi(input logic [9:0] v);
        return v[9:2];
    endfunction
    function automatic logic [7:0] f_lo(input logic [9:0] v);
        return {v[1:0], 6'b0};
    endfunction
    function automatic logic [15:0] f_word(input logic [9:0] v);
        return {v, 6'b0};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge.
    task automatic step(input bit hrd, input logic [4:0] ha, input bit wrd,
                        input logic [3:0] wc, input bit cw, input logic [3:0] cc,
                        input logic [9:0] cd, input string tag);
        logic [7:0] sh_nx;
        host_rd = hrd; host_addr = ha; word_rd = wrd; word_ch = wc;
        cv_wr = cw; cv_ch = cc; cv_res = cd;
        sh_nx = m_shadow;
        if (wrd) begin
            m_word = f_word(m_slot[wc]);
            sh_nx  = f_lo(m_slot[wc]);
        end
        if (hrd) begin
            if (!ha[0]) begin
                m_byte = f_hi(m_slot[ha[4:1]]);
                sh_nx  = f_lo(m_slot[ha[4:1]]);
            end else begin
                m_byte = m_shadow;
            end
        end
        if (cw) m_slot[cc] = cd;
        m_shadow = sh_nx;
        @(posedge clk);
        #1;
        check(tag, {8'h00, host_rdata}, {8'h00, m_byte});
        check(tag, word_rdata, m_word);
        @(negedge clk);
        host_rd = 1'b0; word_rd = 1'b0; cv_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] c, input logic [9:0] d, input string tag);
        step(1'b0, 5'd0, 1'b0, 4'd0, 1'b1, c, d, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        foreach (m_slot[i]) m_slot[i] = '0;
        m_shadow = '0; m_byte = '0; m_word = '0;
        repeat (3) @(negedge clk);
        check("R8 reset byte", {8'h00, host_rdata}, 16'h0000);
        check("R8 reset word", word_rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: lower fetch before any capture returns zero
        step(1'b1, 5'd7, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R8 low before capture");
        for (int c = 0; c < 16; c++)
            step(1'b0, 5'd0, 1'b1, 4'(c), 1'b0, 4'd0, 10'd0, "R8 slot zero");
        // R1 R9: fill each channel, read both halves
        for (int c = 0; c < 16; c++) wr(4'(c), 10'(c * 61 + 3), "R1 fill");
        for (int c = 0; c < 16; c++) begin
            step(1'b1, {4'(c), 1'b0}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R3 R9 upper");
            step(1'b1, {4'(c), 1'b1}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R4 R9 lower");
            step(1'b0, 5'd0, 1'b1, 4'(c), 1'b0, 4'd0, 10'd0, "R1 R2 word");
        end
        // R5: write between halves
        wr(4'd5, 10'h3FF, "R5 setup");
        step(1'b1, {4'd5, 1'b0}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R5 upper");
        wr(4'd5, 10'h000, "R5 mid write");
        step(1'b1, {4'd5, 1'b1}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R5 lower keeps old");
        // R6: cross-channel pair
        wr(4'd2, 10'h2C1, "R6 setup");
        wr(4'd9, 10'h13E, "R6 setup");
        step(1'b1, {4'd2, 1'b0}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R6 upper A");
        step(1'b1, {4'd9, 1'b1}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R6 lower B gives A");
        // R7: word read loads shadow
        step(1'b0, 5'd0, 1'b1, 4'd9, 1'b0, 4'd0, 10'd0, "R7 word");
        step(1'b1, {4'd0, 1'b1}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R7 shadow from word");
        // R10: simultaneous capture, byte path wins
        step(1'b1, {4'd2, 1'b0}, 1'b1, 4'd9, 1'b0, 4'd0, 10'd0, "R10 both");
        step(1'b1, {4'd9, 1'b1}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R10 shadow from byte");
        // R11: read and write same cycle
        step(1'b1, {4'd4, 1'b0}, 1'b1, 4'd4, 1'b1, 4'd4, 10'h2AA, "R11 same cycle");
        step(1'b1, {4'd4, 1'b0}, 1'b0, 4'd0, 1'b0, 4'd0, 10'd0, "R11 after");
        // R12: idle cycles hold outputs
        step(1'b0, 5'd0, 1'b0, 4'd0, 1'b1, 4'd4, 10'h001, "R12 hold");
        // random mix
        for (int n = 0; n < 2000; n++) begin
            step(1'($urandom % 2), 5'($urandom), 1'($urandom % 3 == 0), 4'($urandom),
                 1'($urandom % 2), 4'($urandom), 10'($urandom), "R4 R7 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule